// File: doc/BRIEF.md
# On-the-fly frame error classifier

The classifier sits beside the byte stream of a slave node's receive path. A frame arrives one byte per accepted cycle, with a start marker on the first byte and an end marker on the last. Every byte is sent on to the next port one cycle later, unchanged. A bad check sequence therefore never stalls or cuts forwarding, even though the block keeps a CRC-32 over the whole frame at the same time.

At the end of each frame the block decides two things. First, it decides whether the local receive buffer may be committed. A commit needs a sound frame and, when type filtering is on, the industrial-Ethernet EtherType. Second, it decides which error counter, if any, the frame charges. A frame whose error was already marked upstream by a trailing extra nibble is charged to a separate forwarded-error counter when separate handling is enabled. Any other damaged frame is charged to the local counter. Receive memory may already hold the bytes of a rejected frame, but the missing commit pulse keeps them away from the application.

Top module: `fcs_err_classifier`

## Requirements
- R1: A frame of at least 64 bytes whose CRC-32 residue differs from 0xDEBB20E3 increments `local_err_cnt` by one and leaves `fwd_err_cnt` unchanged when no trailing nibble is flagged. The CRC uses the reflected polynomial 0xEDB88320, starts at 0xFFFFFFFF, runs over every byte including the check sequence, and the check sequence is the complemented CRC sent least significant byte first.
- R2: With `sep_fcs_en` high, a bad frame that has `in_nibble` high together with its end marker increments `fwd_err_cnt` by one and leaves `local_err_cnt` unchanged.
- R3: With `sep_fcs_en` low, a bad frame with the nibble flag is charged to `local_err_cnt` only.
- R4: A frame with a correct check sequence and a length of at least 64 bytes changes neither counter, whether or not the nibble flag is set.
- R5: A frame shorter than 64 bytes (check sequence included) is treated as a check-sequence error, even when its CRC is correct. It is charged by the same rules as R1 to R3.
- R6: In the cycle after each end marker, exactly one of `frame_commit` and `frame_discard` is high for one cycle. Commit needs no error and a type match, where the type is frame bytes 12 and 13 (big-endian) equal to 0x88A4. Without an end marker, neither output is high.
- R7: The type filter is on after reset. A cycle with `cfg_we` high loads `cfg_filter` into it. While the filter is off, a sound frame of any type is committed.
- R8: Each accepted byte, together with its start, end and nibble flags, appears on the outputs exactly one cycle later, whatever the frame's error state. Idle input cycles appear as idle output cycles.
- R9: Each counter is 8 bits wide and stays at 255 once it reaches 255.
- R10: A `cnt_clr` pulse sets both counters to zero. A clear in the same cycle as an increment wins.
- R11: After reset both counters are zero, and the forward and decision outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| in_nibble | input | 1 | Extra trailing nibble seen, valid with the end marker |
| sep_fcs_en | input | 1 | Enable separate counting of upstream-marked errors |
| cfg_we | input | 1 | Load the type-filter bit |
| cfg_filter | input | 1 | New type-filter value |
| cnt_clr | input | 1 | Clear both error counters |
| out_valid | output | 1 | Forwarded byte present |
| out_sof | output | 1 | Forwarded first-byte marker |
| out_eof | output | 1 | Forwarded last-byte marker |
| out_data | output | 8 | Forwarded byte |
| out_nibble | output | 1 | Forwarded nibble flag |
| frame_commit | output | 1 | Receive buffer may be committed |
| frame_discard | output | 1 | Receive buffer must be dropped |
| local_err_cnt | output | 8 | Locally detected error count |
| fwd_err_cnt | output | 8 | Upstream-marked error count |

## Verification
Frames are swept across every combination of length, check-sequence state, nibble flag, separate-handling enable and EtherType. The lengths are 20, 63, 64, 65 and 97 bytes. The 63 and 64 byte cases separate the short-frame rule from a true CRC fault. The nibble and enable pairs separate the forwarded and local counters from each other, and from the good-frame case where the nibble must be ignored. The filter is exercised both on and off, so that a type mismatch is told apart from a frame error. Long runs of bad frames drive both counters into saturation. Frames with idle gaps check the one-cycle forwarding, and a clear that lands on an end marker shows that the clear wins.

// File: rtl/fcs_cls_pkg.sv
`timescale 1ns/1ps
package fcs_cls_pkg;

   localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
   localparam logic [31:0] CRC_INIT    = 32'hFFFFFFFF;
   localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

   typedef enum logic [1:0] {
      KIND_NONE  = 2'd0,
      KIND_LOCAL = 2'd1,
      KIND_FWD   = 2'd2
   } err_kind_e;

   typedef struct packed {
      logic       valid;
      logic       sof;
      logic       eof;
      logic       nib;
      logic [7:0] data;
   } beat_t;

   // One byte of reflected CRC-32, least significant bit first.
   function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
      logic [31:0] r;
      r = c ^ {24'd0, b};
      for (int k = 0; k < 8; k++) begin
         r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/fcs_crc_acc.sv
`timescale 1ns/1ps
module fcs_crc_acc
   import fcs_cls_pkg::*;
#(
   parameter logic [31:0] RESIDUE = CRC_RESIDUE
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       beat_valid,
   input  logic       beat_sof,
   input  logic [7:0] beat_data,
   output logic       residue_ok
);

   logic [31:0] crc_q;
   logic [31:0] crc_base;
   logic [31:0] crc_nxt;

   always_comb begin
      crc_base   = beat_sof ? CRC_INIT : crc_q;
      crc_nxt    = crc_byte(crc_base, beat_data);
      residue_ok = (crc_nxt == RESIDUE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q <= CRC_INIT;
      end else if (beat_valid) begin
         crc_q <= crc_nxt;
      end
   end

endmodule

// File: rtl/fcs_hdr_track.sv
`timescale 1ns/1ps
module fcs_hdr_track #(
   parameter int          MIN_LEN  = 64,
   parameter int          TYPE_OFS = 12,
   parameter logic [15:0] ETYPE    = 16'h88A4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       beat_valid,
   input  logic       beat_sof,
   input  logic [7:0] beat_data,
   output logic       len_ok,
   output logic       type_ok
);

   localparam int LEN_MAX = (MIN_LEN > TYPE_OFS + 2) ? MIN_LEN : TYPE_OFS + 2;
   localparam int LEN_W   = $clog2(LEN_MAX + 1);

   localparam logic [LEN_W-1:0] POS_HI  = LEN_W'(TYPE_OFS);
   localparam logic [LEN_W-1:0] POS_LO  = LEN_W'(TYPE_OFS + 1);
   localparam logic [LEN_W-1:0] CAP_V   = LEN_W'(LEN_MAX);
   localparam logic [LEN_W:0]   MIN_V   = (LEN_W + 1)'(MIN_LEN);

   if (TYPE_OFS < 0) begin : g_bad_ofs
      $error("fcs_hdr_track: TYPE_OFS must not be negative");
   end
   if (MIN_LEN < 1) begin : g_bad_min
      $error("fcs_hdr_track: MIN_LEN must be positive");
   end

   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] idx;
   logic [LEN_W:0]   idx_p1;
   logic [7:0]       hi_q;
   logic             match_q;
   logic             match_now;

   always_comb begin
      idx       = beat_sof ? '0 : cnt_q;
      idx_p1    = {1'b0, idx} + (LEN_W + 1)'(1);
      len_ok    = (idx_p1 >= MIN_V);
      match_now = ({hi_q, beat_data} == ETYPE);
      if (idx == POS_LO) begin
         type_ok = match_now;
      end else if (idx > POS_LO) begin
         type_ok = match_q;
      end else begin
         type_ok = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         hi_q    <= '0;
         match_q <= 1'b0;
      end else if (beat_valid) begin
         cnt_q <= (idx == CAP_V) ? idx : idx + LEN_W'(1);
         if (beat_sof) begin
            match_q <= 1'b0;
         end
         if (idx == POS_HI) begin
            hi_q <= beat_data;
         end
         if (idx == POS_LO) begin
            match_q <= match_now;
         end
      end
   end

endmodule

// File: rtl/fcs_sat_cnt.sv
`timescale 1ns/1ps
module fcs_sat_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);

   localparam logic [W-1:0] TOP_V = {W{1'b1}};

   if (W < 1) begin : g_bad_w
      $error("fcs_sat_cnt: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (clr) begin
         q <= '0;
      end else if (inc && (q != TOP_V)) begin
         q <= q + W'(1);
      end
   end

endmodule

// File: rtl/fcs_err_classifier.sv
`timescale 1ns/1ps
module fcs_err_classifier
   import fcs_cls_pkg::*;
#(
   parameter int          CNT_W       = 8,
   parameter int          MIN_LEN     = 64,
   parameter int          TYPE_OFS    = 12,
   parameter logic [15:0] ETYPE       = 16'h88A4,
   parameter bit          SEP_SUPPORT = 1'b1,
   parameter bit          FILTER_RST  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eof,
   input  logic [7:0]       in_data,
   input  logic             in_nibble,
   input  logic             sep_fcs_en,
   input  logic             cfg_we,
   input  logic             cfg_filter,
   input  logic             cnt_clr,
   output logic             out_valid,
   output logic             out_sof,
   output logic             out_eof,
   output logic [7:0]       out_data,
   output logic             out_nibble,
   output logic             frame_commit,
   output logic             frame_discard,
   output logic [CNT_W-1:0] local_err_cnt,
   output logic [CNT_W-1:0] fwd_err_cnt
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("fcs_err_classifier: CNT_W must be at least 2");
   end
   if (MIN_LEN < TYPE_OFS + 2) begin : g_bad_len
      $error("fcs_err_classifier: MIN_LEN must cover the type field");
   end

   logic      crc_ok;
   logic      len_ok;
   logic      type_ok;
   logic      to_fwd;
   logic      eof_now;
   logic      frame_err;
   logic      accept;
   logic      filt_q;
   err_kind_e kind;
   beat_t     beat_in;
   beat_t     beat_q;
   logic      commit_q;
   logic      discard_q;

   assign eof_now = in_valid & in_eof;

   fcs_crc_acc #(
      .RESIDUE (CRC_RESIDUE)
   ) u_crc (
      .clk        (clk),
      .rst_n      (rst_n),
      .beat_valid (in_valid),
      .beat_sof   (in_sof),
      .beat_data  (in_data),
      .residue_ok (crc_ok)
   );

   fcs_hdr_track #(
      .MIN_LEN  (MIN_LEN),
      .TYPE_OFS (TYPE_OFS),
      .ETYPE    (ETYPE)
   ) u_hdr (
      .clk        (clk),
      .rst_n      (rst_n),
      .beat_valid (in_valid),
      .beat_sof   (in_sof),
      .beat_data  (in_data),
      .len_ok     (len_ok),
      .type_ok    (type_ok)
   );

   // Upstream-marked errors only get their own counter in the separate variant.
   if (SEP_SUPPORT) begin : g_sep
      assign to_fwd = sep_fcs_en & in_nibble;
   end else begin : g_nosep
      logic unused_sep;
      assign unused_sep = sep_fcs_en;
      assign to_fwd     = 1'b0;
   end

   always_comb begin
      frame_err = ~crc_ok | ~len_ok;
      accept    = ~frame_err & (type_ok | ~filt_q);
      if (!frame_err) begin
         kind = KIND_NONE;
      end else if (to_fwd) begin
         kind = KIND_FWD;
      end else begin
         kind = KIND_LOCAL;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         filt_q <= FILTER_RST;
      end else if (cfg_we) begin
         filt_q <= cfg_filter;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         commit_q  <= 1'b0;
         discard_q <= 1'b0;
      end else begin
         commit_q  <= eof_now & accept;
         discard_q <= eof_now & ~accept;
      end
   end

   assign frame_commit  = commit_q;
   assign frame_discard = discard_q;

   fcs_sat_cnt #(
      .W (CNT_W)
   ) u_cnt_local (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (eof_now && (kind == KIND_LOCAL)),
      .q     (local_err_cnt)
   );

   fcs_sat_cnt #(
      .W (CNT_W)
   ) u_cnt_fwd (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (eof_now && (kind == KIND_FWD)),
      .q     (fwd_err_cnt)
   );

   // Fixed one-cycle forwarding stage, independent of any error state.
   always_comb begin
      beat_in.valid = in_valid;
      beat_in.sof   = in_valid & in_sof;
      beat_in.eof   = in_valid & in_eof;
      beat_in.nib   = in_valid & in_eof & in_nibble;
      beat_in.data  = in_valid ? in_data : 8'd0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_q <= '0;
      end else begin
         beat_q <= beat_in;
      end
   end

   assign out_valid  = beat_q.valid;
   assign out_sof    = beat_q.sof;
   assign out_eof    = beat_q.eof;
   assign out_nibble = beat_q.nib;
   assign out_data   = beat_q.data;

endmodule

// File: rtl/fcs_cls_checker.sv
`timescale 1ns/1ps
module fcs_cls_checker #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_eof,
   input logic [7:0]       in_data,
   input logic             cnt_clr,
   input logic             out_valid,
   input logic [7:0]       out_data,
   input logic             frame_commit,
   input logic             frame_discard,
   input logic [CNT_W-1:0] local_err_cnt,
   input logic [CNT_W-1:0] fwd_err_cnt
);

   localparam logic [CNT_W-1:0] TOP_V = {CNT_W{1'b1}};

   AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_eof |=> $countones({frame_commit, frame_discard}) == 1); // R6

   AST_NO_SPURIOUS_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_eof) |=> !frame_commit && !frame_discard); // R6

   AST_FWD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_valid == $past(in_valid)) && (!out_valid || out_data == $past(in_data))); // R8

   AST_COUNT_ONLY_AT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_clr && !(in_valid && in_eof) |=> $stable(local_err_cnt) && $stable(fwd_err_cnt)); // R1

   AST_SINGLE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_clr |=> $stable(local_err_cnt) || $stable(fwd_err_cnt)); // R2

   AST_LOCAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_clr && local_err_cnt != TOP_V |=>
         local_err_cnt == $past(local_err_cnt) || local_err_cnt == $past(local_err_cnt) + CNT_W'(1)); // R1

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_clr && local_err_cnt == TOP_V |=> local_err_cnt == TOP_V); // R9

   AST_NO_OVERFLOW_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_clr && fwd_err_cnt == TOP_V |=> fwd_err_cnt == TOP_V); // R9

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> local_err_cnt == '0 && fwd_err_cnt == '0); // R10

endmodule

bind fcs_err_classifier fcs_cls_checker #(
   .CNT_W (CNT_W)
) u_fcs_cls_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .in_eof        (in_eof),
   .in_data       (in_data),
   .cnt_clr       (cnt_clr),
   .out_valid     (out_valid),
   .out_data      (out_data),
   .frame_commit  (frame_commit),
   .frame_discard (frame_discard),
   .local_err_cnt (local_err_cnt),
   .fwd_err_cnt   (fwd_err_cnt)
);

// File: tb/fcs_err_classifier_test.sv
`timescale 1ns/1ps
module fcs_err_classifier_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_sof = 1'b0;
   logic       in_eof = 1'b0;
   logic [7:0] in_data = 8'd0;
   logic       in_nibble = 1'b0;
   logic       sep_fcs_en = 1'b0;
   logic       cfg_we = 1'b0;
   logic       cfg_filter = 1'b0;
   logic       cnt_clr = 1'b0;
   logic       out_valid;
   logic       out_sof;
   logic       out_eof;
   logic [7:0] out_data;
   logic       out_nibble;
   logic       frame_commit;
   logic       frame_discard;
   logic [7:0] local_err_cnt;
   logic [7:0] fwd_err_cnt;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 1'b0;
   int  exp_loc = 0;
   int  exp_fwd = 0;
   bit  exp_filt = 1'b1;
   logic [7:0] fb [0:255];

   always #2.5 clk = ~clk;

   fcs_err_classifier uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .in_sof        (in_sof),
      .in_eof        (in_eof),
      .in_data       (in_data),
      .in_nibble     (in_nibble),
      .sep_fcs_en    (sep_fcs_en),
      .cfg_we        (cfg_we),
      .cfg_filter    (cfg_filter),
      .cnt_clr       (cnt_clr),
      .out_valid     (out_valid),
      .out_sof       (out_sof),
      .out_eof       (out_eof),
      .out_data      (out_data),
      .out_nibble    (out_nibble),
      .frame_commit  (frame_commit),
      .frame_discard (frame_discard),
      .local_err_cnt (local_err_cnt),
      .fwd_err_cnt   (fwd_err_cnt)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
      logic [31:0] r;
      r = c ^ {24'd0, b};
      for (int k = 0; k < 8; k++) begin
         if (r[0]) r = (r >> 1) ^ 32'hEDB88320;
         else      r = r >> 1;
      end
      return r;
   endfunction

   task automatic send(input int len, input bit et, input bit bad, input bit nib,
                       input bit gaps, input bit clr_eof, input string dtag);
      logic [31:0] crc;
      bit err;
      bit to_fwd;
      bit exp_commit;
      int fwd_bad;
      string ctag;
      crc = 32'hFFFFFFFF;
      for (int i = 0; i < len - 4; i++) begin
         if (i == 12)      fb[i] = et ? 8'h88 : 8'h08;
         else if (i == 13) fb[i] = et ? 8'hA4 : 8'h00;
         else              fb[i] = 8'((i * 37 + len * 5 + 3) & 255);
         crc = ref_crc(crc, fb[i]);
      end
      crc = ~crc;
      for (int k = 0; k < 4; k++) fb[len - 4 + k] = crc[8*k +: 8];
      if (bad) fb[len - 1] = fb[len - 1] ^ 8'h5A;

      err        = bad || (len < 64);
      to_fwd     = err && nib && sep_fcs_en;
      exp_commit = !err && (et || !exp_filt);
      if (!err)                 ctag = "R4";
      else if (len < 64)        ctag = "R5";
      else if (to_fwd)          ctag = "R2";
      else if (nib)             ctag = "R3";
      else                      ctag = "R1";

      fwd_bad = 0;
      for (int i = 0; i < len; i++) begin
         in_valid  = 1'b1;
         in_sof    = (i == 0);
         in_eof    = (i == len - 1);
         in_data   = fb[i];
         in_nibble = (i == len - 1) && nib;
         cnt_clr   = clr_eof && (i == len - 1);
         @(negedge clk);
         if (!(out_valid && out_data == fb[i] && out_sof == (i == 0) &&
               out_eof == (i == len - 1) && out_nibble == ((i == len - 1) && nib)))
            fwd_bad++;
         in_valid  = 1'b0;
         in_sof    = 1'b0;
         in_eof    = 1'b0;
         in_nibble = 1'b0;
         cnt_clr   = 1'b0;
         if (gaps && (i % 3 == 1) && (i != len - 1)) begin
            @(negedge clk);
            if (out_valid) fwd_bad++;
         end
      end
      // R8: every byte forwarded one cycle later, idle gaps preserved
      chk(fwd_bad == 0, "R8", fwd_bad, 0);

      if (clr_eof) begin
         exp_loc = 0;
         exp_fwd = 0;
         ctag = "R10";
      end else if (err) begin
         if (to_fwd) begin
            if (exp_fwd < 255) exp_fwd++;
         end else begin
            if (exp_loc < 255) exp_loc++;
         end
      end
      chk({frame_commit, frame_discard} == {exp_commit, !exp_commit}, dtag,
          {frame_commit, frame_discard}, {exp_commit, !exp_commit});
      chk(local_err_cnt == 8'(exp_loc) && fwd_err_cnt == 8'(exp_fwd), ctag,
          {local_err_cnt, fwd_err_cnt}, (exp_loc << 8) | exp_fwd);
      @(negedge clk);
      // R6: decision is a single-cycle pulse
      chk(!frame_commit && !frame_discard, "R6", {frame_commit, frame_discard}, 0);
   endtask

   task automatic clear_all();
      cnt_clr = 1'b1;
      @(negedge clk);
      cnt_clr = 1'b0;
      exp_loc = 0;
      exp_fwd = 0;
      chk(local_err_cnt == 0 && fwd_err_cnt == 0, "R10", {local_err_cnt, fwd_err_cnt}, 0);
   endtask

   initial begin
      int lens [5] = '{20, 63, 64, 65, 97};
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk(local_err_cnt == 0 && fwd_err_cnt == 0, "R11", {local_err_cnt, fwd_err_cnt}, 0);
      chk(!out_valid && !frame_commit && !frame_discard, "R11",
          {out_valid, frame_commit, frame_discard}, 0);

      // R7: filter on after reset drops a sound frame of another type
      send(64, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
      send(64, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7");

      // Sweep of length, FCS state, nibble, separate handling and type
      for (int s = 0; s < 2; s++) begin
         sep_fcs_en = s[0];
         foreach (lens[li]) begin
            for (int m = 0; m < 8; m++) begin
               send(lens[li], m[2], m[1], m[0], (m == 5), 1'b0, "R6");
            end
         end
      end

      // R7: filter off commits sound frames of any type
      cfg_we = 1'b1; cfg_filter = 1'b0;
      @(negedge clk);
      cfg_we = 1'b0;
      exp_filt = 1'b0;
      for (int m = 0; m < 4; m++) send(64, m[1], m[0], 1'b0, 1'b0, 1'b0, "R7");
      cfg_we = 1'b1; cfg_filter = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      exp_filt = 1'b1;
      send(65, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");

      // R9: saturation of both counters
      clear_all();
      sep_fcs_en = 1'b1;
      for (int n = 0; n < 258; n++) send(20, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
      for (int n = 0; n < 258; n++) send(20, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
      chk(local_err_cnt == 8'd255 && fwd_err_cnt == 8'd255, "R9",
          {local_err_cnt, fwd_err_cnt}, 16'hFFFF);

      // R10: clear coinciding with an increment wins
      send(70, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R6");
      send(70, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
      send(70, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R6");
      send(66, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
      clear_all();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule